// File: doc/BRIEF.md
# Serial TDM Timeslot Enable Generator

This block turns a bit clock and a frame pulse into the transmit and receive enable windows for a serial time-division bus. The bus has 32 channels of 8 bits each, so a frame is 256 bit times long. In internal timing mode the block counts bit positions from the frame pulse. A 4-bit timing code picks a data window. The window is either a partial or whole window in channel 0, or one to three whole channels starting at channel 2. Channel 1 is reserved for an 8-bit control byte. That byte is shifted out MSB first when its own enable bit is set. In every bit time that nothing enables, the serial output is released (output enable low).

In external timing mode the transmit and receive enables come from two input pins, delayed by one register stage. Whatever the mode, the byte arriving in channel 1 on the serial input is collected every frame and presented as a status byte. A clock-rate bit lets the input clock run at the bit rate or at twice the bit rate. In the second case every bit lasts two clocks, and the phase is aligned to the frame pulse.

Top module: `tdm_slot_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `tx_en`, `rx_en`, `ser_out`, `ser_oe` and `chan1_status` are all zero after that edge.
- R2: With `int_mode` low, `tx_en` and `rx_en` equal the values of `ext_tx_en` and `ext_rx_en` at the previous edge. `ser_oe` equals that `ext_tx_en`, and `ser_out` equals `tx_bit` when that `ext_tx_en` was high.
- R3: With `int_mode` high, `ext_tx_en` and `ext_rx_en` have no effect. No data window or channel-1 drive occurs before the first frame pulse after reset.
- R4: A frame pulse sampled high at an edge makes the outputs after that edge show bit position 0 (channel 0, bit 0). The position then advances through 256 bit times and wraps to 0 by itself.
- R5: In internal mode `tx_en` and `rx_en` are both high exactly in the bit times selected by `timing_code`. Codes 0 to 4 select channel 0 bits 0 to 0, 0 to 1, 0 to 5, 0 to 6 and 0 to 7. Codes 5, 6 and 7 select all of channel 2, 3 and 4. Code 8 selects channels 2 and 3, and code 9 selects channels 2 to 4. Codes 10 to 15 select nothing.
- R6: With `rate_1x` low, each bit position lasts two clocks, and the first clock of each bit is the clock after the frame pulse edge. With `rate_1x` high, each bit position lasts one clock.
- R7: In internal mode with `ch1_en` high, `ser_oe` is high in channel 1 and `ser_out` carries `ctrl_byte` MSB first. Bit 7 goes out in channel 1 bit 0.
- R8: In internal mode `ser_oe` is low in every bit time outside the data window and outside an enabled channel 1. Whenever `ser_oe` is low, `ser_out` is zero.
- R9: The value of `ser_in` at the last clock of each channel-1 bit is shifted in MSB first. `chan1_status` takes the complete byte at the edge that ends channel 1 bit 7. This happens in every frame, whatever the values of `ch1_en` and `int_mode`.
- R10: In internal mode, during the data window, `ser_oe` is high and `ser_out` equals `tx_bit` at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock (bit rate or twice the bit rate) |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_pulse | input | 1 | Frame start marker, one clock wide |
| int_mode | input | 1 | 1 = internal timing, 0 = external timing |
| rate_1x | input | 1 | 1 = clock at bit rate, 0 = clock at twice the bit rate |
| ch1_en | input | 1 | Enables control-byte drive in channel 1 |
| timing_code | input | 4 | Data window selection code |
| ctrl_byte | input | 8 | Control byte sent in channel 1 |
| ext_tx_en | input | 1 | External transmit enable (external mode) |
| ext_rx_en | input | 1 | External receive enable (external mode) |
| tx_bit | input | 1 | Data bit to send in a transmit window |
| ser_in | input | 1 | Serial bus input |
| tx_en | output | 1 | Registered transmit enable |
| rx_en | output | 1 | Registered receive enable |
| ser_out | output | 1 | Serial data out, zero when not driven |
| ser_oe | output | 1 | Output enable for the serial line |
| chan1_status | output | 8 | Last complete channel-1 byte received |

## Verification
Each enable and serial output is registered from the next bit position. Its value for the inputs sampled at one rising edge is therefore visible right after that same edge and stays until the next one. The bench drives inputs at the falling edge and advances its reference counter at the rising edge. It compares at the following falling edge, so every check sees exactly one register stage. The status byte changes only at the edge that ends the last channel-1 bit. Its check fires only at the falling edge after that edge, which is 8 or 16 clocks after the first channel-1 bit began, depending on the clock rate.

// File: rtl/tdm_slot_pkg.sv
// Package: shared timing-code encoding for the TDM timeslot enable generator.
// Assumes a 4-bit code; values outside the enum select no data window.
package tdm_slot_pkg;

    typedef enum logic [3:0] {
        TC_CH0_B1  = 4'd0,
        TC_CH0_B2  = 4'd1,
        TC_CH0_B6  = 4'd2,
        TC_CH0_B7  = 4'd3,
        TC_CH0_B8  = 4'd4,
        TC_CH2     = 4'd5,
        TC_CH3     = 4'd6,
        TC_CH4     = 4'd7,
        TC_CH2_3   = 4'd8,
        TC_CH2_4   = 4'd9
    } slot_code_e;

    // Number of leading channel-0 bits enabled by a partial-window code.
    function automatic int unsigned ch0_width(input logic [3:0] code);
        case (code)
            TC_CH0_B1: return 1;
            TC_CH0_B2: return 2;
            TC_CH0_B6: return 6;
            TC_CH0_B7: return 7;
            TC_CH0_B8: return 8;
            default:   return 0;
        endcase
    endfunction

endpackage

// File: rtl/tdm_bit_counter.sv
// Module: bit position counter for one TDM frame.
// Resets the position to zero on the frame pulse. In twice-rate mode it
// advances only every second clock, with the phase cleared by the pulse.
// Assumes the frame pulse is one clock wide. It provides both the current
// and the next position, so that downstream registers can align to the counter.
module tdm_bit_counter #(
    parameter int unsigned FRAME_BITS = 256,
    localparam int unsigned POS_W = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_pulse,
    input  logic             rate_1x,
    output logic [POS_W-1:0] pos_q,
    output logic             phase_q,
    output logic [POS_W-1:0] pos_nx,
    output logic             synced_nx,
    output logic             bit_end
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

    logic synced_q;
    logic phase_nx;
    logic advance;

    // Next-state calculation for position, phase and frame lock.
    always_comb begin
        advance   = rate_1x || phase_q;
        synced_nx = synced_q || frame_pulse;
        if (frame_pulse) begin
            pos_nx   = '0;
            phase_nx = 1'b0;
        end else if (advance) begin
            pos_nx   = (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
            phase_nx = 1'b0;
        end else begin
            pos_nx   = pos_q;
            phase_nx = 1'b1;
        end
        bit_end = synced_q && !frame_pulse && advance;
    end

    // State registers for the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q    <= '0;
            phase_q  <= 1'b0;
            synced_q <= 1'b0;
        end else begin
            pos_q    <= pos_nx;
            phase_q  <= phase_nx;
            synced_q <= synced_nx;
        end
    end

endmodule

// File: rtl/tdm_window_decode.sv
// Module: combinational decode of a bit position into the data window and
// the channel-1 slot. It assumes channels of BITS_PER_CH bits with the
// channel number in the upper position bits.
module tdm_window_decode
    import tdm_slot_pkg::*;
#(
    parameter int unsigned POS_W       = 8,
    parameter int unsigned BITS_PER_CH = 8,
    localparam int unsigned BIT_W = $clog2(BITS_PER_CH),
    localparam int unsigned CH_W  = POS_W - BIT_W
) (
    input  logic [3:0]       code,
    input  logic [POS_W-1:0] pos,
    output logic             data_win,
    output logic             ch1_slot,
    output logic [BIT_W-1:0] bit_idx
);
    logic [CH_W-1:0] chan;
    int unsigned     lim;

    // Split the position and compare it with the selected window.
    always_comb begin
        chan     = pos[POS_W-1:BIT_W];
        bit_idx  = pos[BIT_W-1:0];
        lim      = ch0_width(code);
        ch1_slot = (chan == CH_W'(1));
        case (code)
            TC_CH0_B1, TC_CH0_B2, TC_CH0_B6, TC_CH0_B7, TC_CH0_B8:
                data_win = (chan == '0) && (int'(bit_idx) < int'(lim));
            TC_CH2:   data_win = (chan == CH_W'(2));
            TC_CH3:   data_win = (chan == CH_W'(3));
            TC_CH4:   data_win = (chan == CH_W'(4));
            TC_CH2_3: data_win = (chan == CH_W'(2)) || (chan == CH_W'(3));
            TC_CH2_4: data_win = (chan >= CH_W'(2)) && (chan <= CH_W'(4));
            default:  data_win = 1'b0;
        endcase
    end

endmodule

// File: rtl/tdm_chan_capture.sv
// Module: collects the channel-1 byte from the serial input, MSB first.
// A bit is sampled on the last clock of each channel-1 bit time, which the
// counter reports with bit_end. The byte is published at the end of bit 7.
// This runs in both modes and whatever the value of the channel-1 enable.
module tdm_chan_capture #(
    parameter int unsigned POS_W       = 8,
    parameter int unsigned BITS_PER_CH = 8,
    localparam int unsigned BIT_W = $clog2(BITS_PER_CH),
    localparam int unsigned CH_W  = POS_W - BIT_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bit_end,
    input  logic [POS_W-1:0]       pos_q,
    input  logic                   ser_in,
    output logic [BITS_PER_CH-1:0] status_q
);
    logic [BITS_PER_CH-1:0] shift_q;
    logic [BITS_PER_CH-1:0] shift_nx;
    logic                   in_slot;
    logic                   last_bit;

    // Work out whether this edge ends a channel-1 bit.
    always_comb begin
        in_slot  = (pos_q[POS_W-1:BIT_W] == CH_W'(1)) && bit_end;
        last_bit = (pos_q[BIT_W-1:0] == BIT_W'(BITS_PER_CH - 1));
        shift_nx = {shift_q[BITS_PER_CH-2:0], ser_in};
    end

    // Shift register and published status byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q  <= '0;
            status_q <= '0;
        end else if (in_slot) begin
            shift_q <= shift_nx;
            if (last_bit) status_q <= shift_nx;
        end
    end

endmodule

// File: rtl/tdm_slot_timer.sv
// Module: TDM timeslot enable generator, top level.
// Internal mode: the enables and the serial drive follow the bit counter and
// the timing code, and channel 1 carries the control byte. External mode:
// the enables are the external pins, registered once. All outputs are
// registered from the next counter state, so they change at bit boundaries.
// Assumes the control byte and the mode inputs are register outputs that are
// steady during a frame.
module tdm_slot_timer #(
    parameter int unsigned CHANNELS    = 32,
    parameter int unsigned BITS_PER_CH = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_pulse,
    input  logic                   int_mode,
    input  logic                   rate_1x,
    input  logic                   ch1_en,
    input  logic [3:0]             timing_code,
    input  logic [BITS_PER_CH-1:0] ctrl_byte,
    input  logic                   ext_tx_en,
    input  logic                   ext_rx_en,
    input  logic                   tx_bit,
    input  logic                   ser_in,
    output logic                   tx_en,
    output logic                   rx_en,
    output logic                   ser_out,
    output logic                   ser_oe,
    output logic [BITS_PER_CH-1:0] chan1_status
);
    localparam int unsigned FRAME_BITS = CHANNELS * BITS_PER_CH;
    localparam int unsigned POS_W      = $clog2(FRAME_BITS);
    localparam int unsigned BIT_W      = $clog2(BITS_PER_CH);
    localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(BITS_PER_CH - 1);

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_nx;
    logic             phase_q;
    logic             synced_nx;
    logic             bit_end;
    logic             data_win;
    logic             ch1_slot;
    logic [BIT_W-1:0] bit_idx;

    logic             win_i, c1_i;
    logic             tx_d, rx_d, oe_d, out_d;

    tdm_bit_counter #(
        .FRAME_BITS (FRAME_BITS)
    ) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_pulse (frame_pulse),
        .rate_1x     (rate_1x),
        .pos_q       (pos_q),
        .phase_q     (phase_q),
        .pos_nx      (pos_nx),
        .synced_nx   (synced_nx),
        .bit_end     (bit_end)
    );

    tdm_window_decode #(
        .POS_W       (POS_W),
        .BITS_PER_CH (BITS_PER_CH)
    ) u_decode (
        .code     (timing_code),
        .pos      (pos_nx),
        .data_win (data_win),
        .ch1_slot (ch1_slot),
        .bit_idx  (bit_idx)
    );

    tdm_chan_capture #(
        .POS_W       (POS_W),
        .BITS_PER_CH (BITS_PER_CH)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_end  (bit_end),
        .pos_q    (pos_q),
        .ser_in   (ser_in),
        .status_q (chan1_status)
    );

    // Select the output values for the next bit time by mode.
    always_comb begin
        win_i = synced_nx && data_win;
        c1_i  = synced_nx && ch1_en && ch1_slot;
        if (int_mode) begin
            tx_d  = win_i;
            rx_d  = win_i;
            oe_d  = win_i || c1_i;
            out_d = c1_i ? ctrl_byte[TOP_BIT - bit_idx] : (win_i && tx_bit);
        end else begin
            tx_d  = ext_tx_en;
            rx_d  = ext_rx_en;
            oe_d  = ext_tx_en;
            out_d = ext_tx_en && tx_bit;
        end
    end

    // Output registers, aligned with the counter state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en   <= 1'b0;
            rx_en   <= 1'b0;
            ser_oe  <= 1'b0;
            ser_out <= 1'b0;
        end else begin
            tx_en   <= tx_d;
            rx_en   <= rx_d;
            ser_oe  <= oe_d;
            ser_out <= out_d;
        end
    end

endmodule

// File: rtl/tdm_slot_timer_chk.sv
// Module: property checker for tdm_slot_timer, attached by bind.
// Assumes that rst_n is synchronous. The checker's own "started" flag keeps
// $past away from cycles that were still in reset.
module tdm_slot_timer_chk #(
    parameter int unsigned POS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_pulse,
    input logic             int_mode,
    input logic             rate_1x,
    input logic             ext_tx_en,
    input logic             ext_rx_en,
    input logic             tx_en,
    input logic             rx_en,
    input logic             ser_out,
    input logic             ser_oe,
    input logic [POS_W-1:0] pos_q,
    input logic             phase_q
);
    logic started;

    // Marks the cycles that have a reset-free previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    assert_ext_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        started && $past(!int_mode) |-> (tx_en == $past(ext_tx_en)) && (rx_en == $past(ext_rx_en)));

    assert_int_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        started && $past(int_mode) |-> (tx_en == rx_en));

    assert_frame_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        started && $past(frame_pulse) |-> (pos_q == '0) && !phase_q);

    assert_half_rate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        started && $past(!rate_1x) && $past(!phase_q) && $past(!frame_pulse)
        |-> (pos_q == $past(pos_q)) && phase_q);

    assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_oe |-> !ser_out);

    assert_tx_drives_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> ser_oe);

endmodule

bind tdm_slot_timer tdm_slot_timer_chk #(.POS_W(POS_W)) u_slot_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_pulse (frame_pulse),
    .int_mode    (int_mode),
    .rate_1x     (rate_1x),
    .ext_tx_en   (ext_tx_en),
    .ext_rx_en   (ext_rx_en),
    .tx_en       (tx_en),
    .rx_en       (rx_en),
    .ser_out     (ser_out),
    .ser_oe      (ser_oe),
    .pos_q       (pos_q),
    .phase_q     (phase_q)
);

// File: tb/test_tdm_slot_timer.sv
// Bench: random frames mixed with directed cases, compared against a
// reference counter model that follows the requirements.
module test_tdm_slot_timer;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0, frame_pulse = 1'b0, int_mode = 1'b1, rate_1x = 1'b1, ch1_en = 1'b0;
    logic [3:0] timing_code = 4'd0;
    logic [7:0] ctrl_byte = 8'h00;
    logic       ext_tx_en = 1'b0, ext_rx_en = 1'b0, tx_bit = 1'b0, ser_in = 1'b0;
    logic       tx_en, rx_en, ser_out, ser_oe;
    logic [7:0] chan1_status;

    int n_tests = 0;
    int n_fail  = 0;

    int       m_pos = 0;
    bit       m_ph = 0, m_sync = 0;
    bit [7:0] m_sreg = 0, m_stat = 0;

    tdm_slot_timer i_tdm_slot_timer (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .int_mode(int_mode),
        .rate_1x(rate_1x), .ch1_en(ch1_en), .timing_code(timing_code),
        .ctrl_byte(ctrl_byte), .ext_tx_en(ext_tx_en), .ext_rx_en(ext_rx_en),
        .tx_bit(tx_bit), .ser_in(ser_in), .tx_en(tx_en), .rx_en(rx_en),
        .ser_out(ser_out), .ser_oe(ser_oe), .chan1_status(chan1_status)
    );

    // Data window membership according to R5.
    function automatic bit win_of(input logic [3:0] code, input int pos);
        int ch = pos / 8;
        int b  = pos % 8;
        case (code)
            4'd0: return ch == 0 && b < 1;
            4'd1: return ch == 0 && b < 2;
            4'd2: return ch == 0 && b < 6;
            4'd3: return ch == 0 && b < 7;
            4'd4: return ch == 0;
            4'd5: return ch == 2;
            4'd6: return ch == 3;
            4'd7: return ch == 4;
            4'd8: return ch == 2 || ch == 3;
            4'd9: return ch >= 2 && ch <= 4;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One clock: advance the model at the rising edge, compare at the falling edge.
    task automatic step();
        bit adv, stat_due, w, c1, e_tx, e_rx, e_oe, e_out, fp;
        string tag;
        fp  = frame_pulse;
        @(posedge clk);
        adv = rate_1x || m_ph;
        stat_due = 0;
        if (m_sync && !fp && adv && m_pos >= 8 && m_pos < 16) begin
            m_sreg = {m_sreg[6:0], ser_in};
            if (m_pos == 15) begin
                m_stat = m_sreg;
                stat_due = 1;
            end
        end
        if (fp) begin
            m_pos = 0; m_ph = 0; m_sync = 1;
        end else if (adv) begin
            m_pos = (m_pos + 1) % 256; m_ph = 0;
        end else begin
            m_ph = 1;
        end
        if (int_mode) begin
            w  = m_sync && win_of(timing_code, m_pos);
            c1 = m_sync && ch1_en && (m_pos / 8 == 1);
            e_tx = w; e_rx = w; e_oe = w || c1;
            e_out = c1 ? ctrl_byte[7 - (m_pos % 8)] : (w && tx_bit);
            if (fp)            tag = "R4";
            else if (!m_sync)  tag = "R3";
            else if (!rate_1x) tag = "R6";
            else               tag = "R5";
        end else begin
            w = 0; c1 = 0;
            e_tx = ext_tx_en; e_rx = ext_rx_en; e_oe = ext_tx_en;
            e_out = ext_tx_en && tx_bit;
            tag = "R2";
        end
        @(negedge clk);
        chk(tag, "tx_en", {7'd0, tx_en}, {7'd0, e_tx});
        chk(tag, "rx_en", {7'd0, rx_en}, {7'd0, e_rx});
        chk(!int_mode ? "R2" : c1 ? "R7" : w ? "R10" : "R8", "ser_oe", {7'd0, ser_oe}, {7'd0, e_oe});
        chk(!int_mode ? "R2" : c1 ? "R7" : w ? "R10" : "R8", "ser_out", {7'd0, ser_out}, {7'd0, e_out});
        if (stat_due) chk("R9", "chan1_status", chan1_status, m_stat);
    endtask

    initial begin : watchdog
        #(200000 * 4);
        n_fail++;
        $display("FAIL R4 watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd2718));
        // R1: reset state, with noisy inputs driven.
        ext_tx_en = 1'b1; tx_bit = 1'b1; frame_pulse = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "tx_en", {7'd0, tx_en}, 8'd0);
        chk("R1", "rx_en", {7'd0, rx_en}, 8'd0);
        chk("R1", "ser_oe", {7'd0, ser_oe}, 8'd0);
        chk("R1", "ser_out", {7'd0, ser_out}, 8'd0);
        chk("R1", "chan1_status", chan1_status, 8'd0);
        rst_n = 1'b1; frame_pulse = 1'b0;
        // R3: internal mode before any frame pulse, external pins toggling.
        int_mode = 1'b1; timing_code = 4'd4; ch1_en = 1'b1; ctrl_byte = 8'hA5;
        for (int c = 0; c < 20; c++) begin
            ext_tx_en = 1'($urandom); ext_rx_en = 1'($urandom); tx_bit = 1'($urandom);
            step();
        end
        // Random frames, codes 0..11 directed first, then random.
        for (int f = 0; f < 24; f++) begin
            int n;
            timing_code = (f < 12) ? 4'(f) : 4'($urandom);
            rate_1x     = (f == 1 || f == 5) ? 1'b0 : 1'($urandom);
            ch1_en      = (f == 2) ? 1'b0 : 1'($urandom);
            int_mode    = (f == 2) ? 1'b1 : (f % 5 != 4);
            ctrl_byte   = 8'($urandom);
            n = rate_1x ? 256 : 512;
            for (int c = 0; c < n; c++) begin
                ext_tx_en = 1'($urandom); ext_rx_en = 1'($urandom);
                tx_bit = 1'($urandom); ser_in = 1'($urandom);
                frame_pulse = ((c == n - 1) && f != 9) || (f == 7 && c == 100);
                step();
            end
        end
        frame_pulse = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule